// File: doc/BRIEF.md
# SPI Byte Exchange Controller

This block moves one byte at a time over a four-wire synchronous serial link and can sit on either side of it. Software programs a configuration register with the idle clock level, the sampling phase, the bit order, a clock divide select, the role (clock generator or clock follower) and an enable. Writing the data register loads a single shift register. In master role, the write also starts the exchange. Each bit sent out is matched by one bit taken in, so once the byte is finished the data register holds the received byte.

A status flag reports that a byte is finished. It stays set until software reads the status register while the flag is up and then reads the data register. A data write made during an exchange is dropped and leaves a collision bit set in status. In follower role, the serial clock, select and serial input come from outside and are synchronised first. The serial output is only enabled while select is low. If select is pulled low while the block is the clock generator, it drops its master bit, stops the exchange and carries on as a follower.

Register map (byte wide, `reg_addr`): 0 = configuration, 1 = status, 2 = data. Configuration bits: [0] enable, [1] master role, [2] clock idle level (CPOL), [3] phase (CPHA), [4] LSB first, [7:5] divide select. Status bits: [0] done, [1] write collision.

Top module: `spi_xchg`

## Requirements
- R1: After reset, the configuration and status registers read 0x00, `sck_out` is 0 and `sdo_en` is 0.
- R2: When no exchange is running, `sck_out` equals the configured CPOL bit (config bit 2).
- R3: In master role, each half period of `sck_out` lasts 2^s system clocks, where s is the divide select (config bits 7:5). Values of s above 6 are treated as 6, so the divide ratio runs from 2 to 128.
- R4: An exchange has 16 clock edges. With CPHA=0 the input is sampled on odd edges and the output changes on even edges, and the first output bit is on `sdo` before edge 1. With CPHA=1 the input is sampled on even edges and the output changes on odd edges.
- R5: Full duplex. The byte written to the data register appears on `sdo`, and after the exchange the data register reads back the byte received on `sdi`. The order is MSB first when config bit 4 is 0 and LSB first when it is 1.
- R6: Status bit 0 (done) is set at the end of each complete 8-bit exchange.
- R7: Done is cleared only when a data register read follows a status read that returned done set. A data read with no such prior status read leaves done set.
- R8: A data write during an exchange has no effect on the byte being sent or received and sets status bit 1. That bit clears through the same sequence as done.
- R9: In follower role (config bit 1 = 0), the block shifts on the edges of `sck_in` under the same CPOL/CPHA/order rules, and `sdo_en` is high only while `ss_n` is low.
- R10: In follower role, `ss_n` going high part way through a byte restarts the bit count and does not set done.
- R11: If `ss_n` is low while the block is enabled in master role, the master bit clears, the exchange stops without done, and `sck_out` returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on status and data) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| sck_out | output | 1 | Serial clock driven in master role |
| sck_in | input | 1 | Serial clock received in follower role |
| ss_n | input | 1 | Select input, active low |
| sdi | input | 1 | Serial data in (peripheral output in master role, controller output in follower role) |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for `sdo` |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` in the same cycle as the strobe. Flag changes caused by that strobe show up one clock later. In master role the serial clock changes one system clock after each divider tick. Done is visible one clock after the 16th edge. The bench polls status, so it never has to predict that cycle exactly. In follower role, every pin edge reaches the shifter three clocks after it happens, and the bench allows for this by waiting eight clocks between its own edges. The bench also waits several clocks after raising select before it reads status or `sdo_en`. A wire-side model drives `sdi` on update edges and captures `sdo` on sample edges, where the design's output has been stable for at least one half period. It compares each captured byte against the queued expected byte as soon as eight bits are in.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic [2:0] div_sel;
        logic       lsb_first;
        logic       cpha;
        logic       cpol;
        logic       master;
        logic       en;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic busy;
        logic sck;
        logic done;
        logic wcol;
        logic armed;
        logic sck_prev;
    } ctl_t;

endpackage

// File: rtl/spi_xchg_sync.sv
module spi_xchg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_xchg_clkgen.sv
module spi_xchg_clkgen #(
    parameter int SEL_W   = 3,
    parameter int MAX_SEL = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = MAX_SEL + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, half_m1;
    logic [SEL_W-1:0] sel_eff;

    always_comb begin
        sel_eff = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        half_m1 = (CNT_W'(1) << sel_eff) - CNT_W'(1);
        tick    = run && (cnt_q == half_m1);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_xchg_shifter.sv
module spi_xchg_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          abort,
    input  logic          edge_ev,
    input  logic          lead,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          sdi,
    output logic [DW-1:0] sr,
    output logic          sdo,
    output logic          active,
    output logic          done
);
    localparam int NEDGE = 2 * DW;
    localparam int EW    = $clog2(NEDGE);
    localparam logic [EW-1:0] LAST = EW'(NEDGE - 1);

    typedef struct packed {
        logic [DW-1:0] sr;
        logic [EW-1:0] ecnt;
        logic          dout;
    } sh_t;

    sh_t sh_d, sh_q;
    logic sample;

    always_comb begin
        sh_d   = sh_q;
        done   = 1'b0;
        sample = lead ^ cpha;
        if (load) begin
            sh_d.sr   = load_data;
            sh_d.ecnt = '0;
            sh_d.dout = lsb_first ? load_data[0] : load_data[DW-1];
        end else if (abort) begin
            sh_d.ecnt = '0;
        end else if (edge_ev) begin
            done      = (sh_q.ecnt == LAST);
            sh_d.ecnt = done ? '0 : sh_q.ecnt + EW'(1);
            if (sample) begin
                sh_d.sr = lsb_first ? {sdi, sh_q.sr[DW-1:1]} : {sh_q.sr[DW-2:0], sdi};
            end else begin
                sh_d.dout = lsb_first ? sh_q.sr[0] : sh_q.sr[DW-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sr     = sh_q.sr;
    assign sdo    = sh_q.dout;
    assign active = (sh_q.ecnt != '0);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev && sample && !load && !abort) |=> $stable(sh_q.dout));

    // R10
    abort_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (sh_q.ecnt == '0));
endmodule

// File: rtl/spi_xchg.sv
module spi_xchg
    import spi_xchg_pkg::*;
#(
    parameter int DW      = 8,
    parameter int MAX_SEL = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sck_out,
    input  logic          sck_in,
    input  logic          ss_n,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_en
);
    localparam int CFG_W = $bits(cfg_t);

    ctl_t st_d, st_q;
    logic sck_s, ss_s, sdi_s;
    logic wr_cfg, wr_data, rd_stat, rd_data;
    logic xfer_busy, load, start, coll, modf, abort;
    logic tick, m_edge, s_edge, edge_ev, lead, ser_in;
    logic core_active, core_done;
    logic [DW-1:0] core_sr;

    spi_xchg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, ss_n, sdi}),
        .q     ({sck_s, ss_s, sdi_s})
    );

    spi_xchg_clkgen #(.SEL_W(3), .MAX_SEL(MAX_SEL)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.busy),
        .sel   (st_q.cfg.div_sel),
        .tick  (tick)
    );

    spi_xchg_shifter #(.DW(DW)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (reg_wdata),
        .abort     (abort),
        .edge_ev   (edge_ev),
        .lead      (lead),
        .cpha      (st_q.cfg.cpha),
        .lsb_first (st_q.cfg.lsb_first),
        .sdi       (ser_in),
        .sr        (core_sr),
        .sdo       (sdo),
        .active    (core_active),
        .done      (core_done)
    );

    always_comb begin
        wr_cfg    = reg_wr && (reg_addr == ADDR_CFG);
        wr_data   = reg_wr && (reg_addr == ADDR_DATA);
        rd_stat   = reg_rd && (reg_addr == ADDR_STAT);
        rd_data   = reg_rd && (reg_addr == ADDR_DATA);
        xfer_busy = st_q.cfg.master ? st_q.busy : core_active;
        load      = wr_data && !xfer_busy;
        coll      = wr_data && xfer_busy;
        start     = load && st_q.cfg.en && st_q.cfg.master;
        modf      = st_q.cfg.en && st_q.cfg.master && !ss_s;
        abort     = !st_q.cfg.en || modf || (!st_q.cfg.master && ss_s);
        m_edge    = st_q.busy && tick;
        s_edge    = st_q.cfg.en && !st_q.cfg.master && !ss_s && (sck_s != st_q.sck_prev);
        edge_ev   = st_q.cfg.master ? m_edge : s_edge;
        lead      = st_q.cfg.master ? (st_q.sck == st_q.cfg.cpol) : (sck_s != st_q.cfg.cpol);
        ser_in    = st_q.cfg.master ? sdi : sdi_s;

        st_d          = st_q;
        st_d.sck_prev = sck_s;
        if (wr_cfg) begin
            st_d.cfg = cfg_t'(reg_wdata[CFG_W-1:0]);
        end
        if (modf) begin
            st_d.cfg.master = 1'b0;
        end

        if (!st_q.cfg.en || modf) begin
            st_d.busy = 1'b0;
        end else if (start) begin
            st_d.busy = 1'b1;
        end else if (st_q.cfg.master && core_done) begin
            st_d.busy = 1'b0;
        end

        if (st_q.busy && !modf && tick) begin
            st_d.sck = ~st_q.sck;
        end else if (!st_q.busy) begin
            st_d.sck = st_q.cfg.cpol;
        end

        if (rd_stat) begin
            st_d.armed = st_q.done;
        end else if (rd_data) begin
            st_d.armed = 1'b0;
        end

        if (core_done) begin
            st_d.done = 1'b1;
        end else if (rd_data && st_q.armed) begin
            st_d.done = 1'b0;
        end

        if (coll) begin
            st_d.wcol = 1'b1;
        end else if (rd_data && st_q.armed) begin
            st_d.wcol = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CFG:  reg_rdata = DW'(st_q.cfg);
            ADDR_STAT: reg_rdata = DW'({st_q.wcol, st_q.done});
            ADDR_DATA: reg_rdata = core_sr;
            default:   reg_rdata = '0;
        endcase
    end

    assign sck_out = st_q.sck;
    assign sdo_en  = st_q.cfg.en && (st_q.cfg.master || !ss_n);

    // R3
    sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy) && !$stable(st_q.sck)) |-> $past(tick));

    // R6
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> st_q.done);

    // R7
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.done) |-> $past(rd_data && st_q.armed));

    // R8
    wcol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && xfer_busy) |=> st_q.wcol);

    // R11
    modf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.en && st_q.cfg.master && !ss_s) |=> (!st_q.cfg.master && !st_q.busy));
endmodule

// File: tb/spi_xchg_bench.sv
module spi_xchg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       sck_out, sdo, sdo_en;
    logic       sck_in_r = 1'b0, ss_n_r = 1'b1, sdi_r = 1'b0;

    int checks = 0, errors = 0, cyc = 0;
    bit fin = 1'b0;

    always #10 clk = ~clk;
    always @(negedge clk) cyc++;

    spi_xchg u_spi_xchg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_out(sck_out), .sck_in(sck_in_r), .ss_n(ss_n_r), .sdi(sdi_r),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // wire-side model and scoreboard
    logic [7:0] exp_q[$];
    bit m_cpol, m_cpha, m_lsb, act_master, cap_on;
    logic [7:0] bt_tx, cap;
    int ec, cc, dc, first_cyc, half_meas;
    wire sck_w = act_master ? sck_out : sck_in_r;

    function automatic logic bitat(input logic [7:0] b, input int i, input bit lsb);
        return lsb ? b[i] : b[7-i];
    endfunction

    task automatic cap_start(input logic [7:0] btx);
        bt_tx = btx; cap = 8'h00; ec = 0; cc = 0; half_meas = -1;
        sdi_r = bitat(btx, 0, m_lsb);
        dc = m_cpha ? 0 : 1;
        cap_on = 1'b1;
    endtask

    always @(sck_w) begin
        if (cap_on && ec < 16) begin
            ec++;
            if (ec == 1) first_cyc = cyc;
            if (ec == 2) half_meas = cyc - first_cyc;
            if ((sck_w != m_cpol) ^ m_cpha) begin
                if (cc < 8) begin
                    cap[m_lsb ? cc : 7-cc] = sdo;
                    cc++;
                    if (cc == 8) begin
                        if (exp_q.size() == 0) begin
                            checks++; errors++;
                            $display("FAIL R5: actual 0x%0h expected none queued", cap);
                        end else begin
                            check("R5 sdo byte", int'(cap), int'(exp_q.pop_front()));
                        end
                    end
                end
            end else if (dc < 8) begin
                sdi_r = bitat(bt_tx, dc, m_lsb);
                dc++;
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic set_cfg(input bit master, input bit cpol, input bit cpha,
                           input bit lsb, input logic [2:0] sel);
        m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; act_master = master;
        reg_write(2'd0, {sel, lsb, cpha, cpol, master, 1'b1});
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_done(output logic [7:0] st);
        st = 8'h00;
        for (int i = 0; i < 5000; i++) begin
            reg_read(2'd1, st);
            if (st[0]) break;
        end
    endtask

    task automatic master_xfer(input bit cpol, input bit cpha, input bit lsb,
                               input logic [2:0] sel, input logic [7:0] dtx,
                               input logic [7:0] btx);
        logic [7:0] v;
        int hexp;
        hexp = (sel > 6) ? 64 : (1 << sel);
        set_cfg(1'b1, cpol, cpha, lsb, sel);
        check("R2 idle sck", int'(sck_out), int'(cpol));
        cap_start(btx);
        exp_q.push_back(dtx);
        reg_write(2'd2, dtx);
        wait_done(v);
        check("R6 done", int'(v), 1);
        reg_read(2'd2, v);
        check("R5 rx byte", int'(v), int'(btx));
        reg_read(2'd1, v);
        check("R7 cleared", int'(v), 0);
        check("R3 half period", half_meas, hexp);
        check("R4 edge count", ec, 16);
        check("R2 idle after", int'(sck_out), int'(cpol));
        cap_on = 1'b0;
    endtask

    task automatic slave_xfer(input bit cpol, input bit cpha, input bit lsb,
                              input logic [7:0] dtx, input logic [7:0] btx);
        logic [7:0] v;
        cap_on = 1'b0;
        sck_in_r = cpol;
        set_cfg(1'b0, cpol, cpha, lsb, 3'd0);
        reg_write(2'd2, dtx);
        exp_q.push_back(dtx);
        cap_start(btx);
        ss_n_r = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 sdo_en low ss", int'(sdo_en), 1);
        for (int e = 0; e < 16; e++) begin
            sck_in_r = ~sck_in_r;
            repeat (8) @(negedge clk);
        end
        ss_n_r = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 sdo_en high ss", int'(sdo_en), 0);
        reg_read(2'd1, v);
        check("R6 slave done", int'(v), 1);
        reg_read(2'd2, v);
        check("R9 slave rx byte", int'(v), int'(btx));
        reg_read(2'd1, v);
        check("R7 slave cleared", int'(v), 0);
        cap_on = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        reg_read(2'd0, v); check("R1 cfg", int'(v), 0);
        reg_read(2'd1, v); check("R1 status", int'(v), 0);
        check("R1 sck_out", int'(sck_out), 0);
        check("R1 sdo_en", int'(sdo_en), 0);

        // R2 idle high
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
        check("R2 cpol1 idle", int'(sck_out), 1);

        // R3 R4 R5 across modes, orders, divides
        master_xfer(1'b0, 1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C);
        master_xfer(1'b0, 1'b1, 1'b1, 3'd2, 8'h81, 8'h5E);
        master_xfer(1'b1, 1'b0, 1'b0, 3'd1, 8'h0F, 8'hC3);
        master_xfer(1'b1, 1'b1, 1'b1, 3'd7, 8'h6B, 8'h92);
        master_xfer(1'b1, 1'b1, 1'b0, 3'd6, 8'hE4, 8'h17);

        // R7: data read without armed status leaves done set
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
        cap_start(8'h99);
        exp_q.push_back(8'h24);
        reg_write(2'd2, 8'h24);
        repeat (60) @(negedge clk);
        reg_read(2'd2, v); check("R7 rx byte", int'(v), 'h99);
        reg_read(2'd1, v); check("R7 done kept", int'(v), 1);
        reg_read(2'd2, v);
        reg_read(2'd1, v); check("R7 done cleared", int'(v), 0);
        cap_on = 1'b0;

        // R8: write collision
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 3'd3);
        cap_start(8'h4D);
        exp_q.push_back(8'hB2);
        reg_write(2'd2, 8'hB2);
        repeat (10) @(negedge clk);
        reg_write(2'd2, 8'hFF);
        reg_read(2'd1, v); check("R8 wcol set", int'(v), 2);
        wait_done(v); check("R8 done+wcol", int'(v), 3);
        reg_read(2'd2, v); check("R8 rx unaffected", int'(v), 'h4D);
        reg_read(2'd1, v); check("R8 wcol cleared", int'(v), 0);
        cap_on = 1'b0;

        // R9 follower role
        slave_xfer(1'b0, 1'b0, 1'b0, 8'hC6, 8'h5A);
        slave_xfer(1'b1, 1'b1, 1'b1, 8'h1D, 8'hE8);
        slave_xfer(1'b0, 1'b1, 1'b0, 8'h70, 8'h0B);

        // R10: partial byte aborted by ss_n
        sck_in_r = 1'b0;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
        reg_write(2'd2, 8'h33);
        ss_n_r = 1'b0;
        repeat (8) @(negedge clk);
        for (int e = 0; e < 6; e++) begin
            sck_in_r = ~sck_in_r;
            repeat (8) @(negedge clk);
        end
        ss_n_r = 1'b1;
        repeat (6) @(negedge clk);
        reg_read(2'd1, v); check("R10 no done", int'(v), 0);
        slave_xfer(1'b0, 1'b0, 1'b0, 8'h96, 8'hA1);

        // R11: mode fault
        cap_on = 1'b0;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 3'd3);
        reg_write(2'd2, 8'h77);
        repeat (30) @(negedge clk);
        ss_n_r = 1'b0;
        repeat (6) @(negedge clk);
        reg_read(2'd0, v); check("R11 master cleared", int'(v[1]), 0);
        check("R11 sck idle", int'(sck_out), 0);
        reg_read(2'd1, v); check("R11 no done", int'(v), 0);
        ss_n_r = 1'b1;
        repeat (4) @(negedge clk);

        check("R5 queue drained", exp_q.size(), 0);
        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule